// File: doc/BRIEF.md
# Output amplitude keying controller

This block produces the amplitude word that drives the scaling stage of a direct digital synthesizer. It takes a configuration bank (enable, mode select, external-gate bit, counter-reload bit), a 32-bit amplitude register and an external keying pin. From these it builds its own amplitude level. While it is enabled, a priority multiplexer passes that level to the datapath in place of any other amplitude source.

There are two modes. In manual mode the level tracks the programmed scale factor, and the keying pin can optionally gate it to zero. In automatic mode the level ramps up towards the scale factor while the pin is high and down towards zero while the pin is low. It moves by a fixed step once per programmed number of DDS clock cycles. Configuration and register fields are held in shadow registers that load only on the update strobe, so a partly written setup never reaches the output.

Top module: `amp_keyer`

## Requirements
- R1: After reset the block is disabled in manual mode with a zero scale factor. `ownsAmp` is 0 and `ampOut` equals `otherAmp`.
- R2: The amplitude register splits into a ramp-rate divider in bits 31:16, a 14-bit scale factor in bits 15:2 and a step-size code in bits 1:0. These fields and the four configuration bits take effect only at a clock edge where `updateStrobe` is 1. Changing them without the strobe leaves `ampOut` unchanged.
- R3: While the latched enable is 0, `ownsAmp` is 0 and `ampOut` equals `otherAmp`. The keying pin, the mode bit and the gate bit have no effect.
- R4: While the latched enable is 1, `ownsAmp` is 1 and `ampOut` carries the block's own level, whatever `otherAmp` holds.
- R5: In manual mode with the gate bit 0, the level equals the latched scale factor from the edge after the strobe, whatever the pin does.
- R6: In manual mode with the gate bit 1, the level is 0 one edge after the pin is sampled low and equals the scale factor one edge after it is sampled high.
- R7: In automatic mode, each step taken with the pin high sets the level to min(level + step, scale factor).
- R8: In automatic mode, each step taken with the pin low sets the level to level - step, or to 0 if the level is not above the step.
- R9: Step codes 0, 1, 2 and 3 give steps of 1, 2, 4 and 8 LSBs.
- R10: In automatic mode, one step is taken on every N-th clock edge, where N is the latched ramp-rate divider. A divider of 0 behaves as 1.
- R11: At a strobe edge where the reload bit is 1, the ramp counter restarts from zero and no step is taken on that edge. The next step then falls N edges later.
- R12: While disabled, the level and the ramp counter are frozen. After re-enabling, the output resumes from the held level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DDS clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Keying enable, latched on update |
| cfgAutoMode | input | 1 | 0 = manual, 1 = automatic ramp, latched on update |
| cfgExtGate | input | 1 | Manual mode: let the keying pin gate the level to zero, latched on update |
| cfgReload | input | 1 | Restart the ramp counter on each update strobe |
| ampReg | input | 32 | Ramp divider [31:16], scale factor [15:2], step code [1:0] |
| updateStrobe | input | 1 | Loads configuration and fields into the shadow registers |
| keyPin | input | 1 | External keying pin |
| otherAmp | input | 14 | Lower-priority amplitude source |
| ampOut | output | 14 | Amplitude word to the DDS datapath |
| ownsAmp | output | 1 | High while this block drives the amplitude path |

## Verification
A strobe latches the shadow fields at edge E. `ownsAmp` and the output selection change right after E. A manual level or pin response lands one edge later, at E+1. After a strobe that carries the reload bit, the n-th automatic step falls at edge E+n·N. Each check drives its inputs one time unit after a rising edge and samples the outputs one time unit after the edge on which the value is due, so no check depends on process order at an edge. The expected ramp values are computed as closed-form saturated sums from the edge count since the reload strobe.

// File: rtl/amp_key_pkg.sv
package amp_key_pkg;
  parameter int AMP_W  = 14;
  parameter int RATE_W = 16;
  parameter int STEP_W = 2;
  localparam int REG_W = RATE_W + AMP_W + STEP_W;

  typedef struct packed {
    logic              en;
    logic              autoMode;
    logic              extGate;
    logic [RATE_W-1:0] rate;
    logic [AMP_W-1:0]  scale;
    logic [STEP_W-1:0] stepCode;
  } shadow_t;

  typedef struct packed {
    logic run;
    logic manualLoad;
    logic forceZero;
    logic tick;
    logic rise;
  } strobes_t;
endpackage

// File: rtl/amp_key_ctrl.sv
module amp_key_ctrl
  import amp_key_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic             cfgAutoMode,
  input  logic             cfgExtGate,
  input  logic             cfgReload,
  input  logic [REG_W-1:0] ampReg,
  input  logic             updateStrobe,
  input  logic             keyPin,
  output shadow_t          cfg,
  output strobes_t         strb
);
  localparam int RATE_LO = AMP_W + STEP_W;

  logic [RATE_W-1:0] cnt;
  logic [RATE_W-1:0] rateEff;
  logic [RATE_W:0]   cntInc;
  logic              counting;
  logic              reloadNow;
  logic              wrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (updateStrobe) begin
      cfg.en       <= cfgEnable;
      cfg.autoMode <= cfgAutoMode;
      cfg.extGate  <= cfgExtGate;
      cfg.rate     <= ampReg[REG_W-1:RATE_LO];
      cfg.scale    <= ampReg[RATE_LO-1:STEP_W];
      cfg.stepCode <= ampReg[STEP_W-1:0];
    end
  end

  always_comb begin
    rateEff   = (cfg.rate == '0) ? RATE_W'(1) : cfg.rate;
    counting  = cfg.en && cfg.autoMode;
    reloadNow = updateStrobe && cfgReload;
    cntInc    = {1'b0, cnt} + 1'b1;
    wrap      = counting && (cntInc >= {1'b0, rateEff});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (reloadNow) begin
      cnt <= '0;
    end else if (cfg.en) begin
      if (!cfg.autoMode || wrap) cnt <= '0;
      else                       cnt <= cntInc[RATE_W-1:0];
    end
  end

  always_comb begin
    strb.run        = cfg.en;
    strb.manualLoad = cfg.en && !cfg.autoMode;
    strb.forceZero  = cfg.extGate && !keyPin;
    strb.tick       = wrap && !reloadNow;
    strb.rise       = keyPin;
  end

  assert_reload_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    reloadNow |=> cnt == '0);
  assert_count_advance_R10: assert property (@(posedge clk) disable iff (!rstN)
    (counting && !reloadNow) |=> (cnt == '0) || (cnt == $past(cnt) + 1'b1));
  assert_count_frozen_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.en && !reloadNow) |=> $stable(cnt));
endmodule

// File: rtl/amp_key_dp.sv
module amp_key_dp
  import amp_key_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  shadow_t          cfg,
  input  strobes_t         strb,
  input  logic [AMP_W-1:0] otherAmp,
  output logic [AMP_W-1:0] ampOut,
  output logic             ownsAmp
);
  logic [AMP_W-1:0] level;
  logic [AMP_W-1:0] stepVal;
  logic [AMP_W:0]   sumUp;
  logic [AMP_W-1:0] upVal;
  logic [AMP_W-1:0] downVal;
  logic [AMP_W-1:0] levelNext;

  always_comb begin
    stepVal = AMP_W'(1) << cfg.stepCode;
    sumUp   = {1'b0, level} + {1'b0, stepVal};
    upVal   = (sumUp >= {1'b0, cfg.scale}) ? cfg.scale : sumUp[AMP_W-1:0];
    downVal = (level > stepVal) ? (level - stepVal) : '0;
    if (strb.manualLoad)  levelNext = strb.forceZero ? '0 : cfg.scale;
    else if (strb.tick)   levelNext = strb.rise ? upVal : downVal;
    else                  levelNext = level;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         level <= '0;
    else if (strb.run) level <= levelNext;
  end

  always_comb begin
    ownsAmp = strb.run;
    ampOut  = strb.run ? level : otherAmp;
  end

  assert_hold_when_off_R12: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> $stable(level));
  assert_rise_capped_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && strb.tick && strb.rise) |=> level <= $past(cfg.scale));
  assert_fall_monotone_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && strb.tick && !strb.rise) |=> level <= $past(level));
  assert_manual_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.manualLoad && strb.forceZero) |=> level == '0);
endmodule

// File: rtl/amp_keyer.sv
module amp_keyer
  import amp_key_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic             cfgAutoMode,
  input  logic             cfgExtGate,
  input  logic             cfgReload,
  input  logic [31:0]      ampReg,
  input  logic             updateStrobe,
  input  logic             keyPin,
  input  logic [13:0]      otherAmp,
  output logic [13:0]      ampOut,
  output logic             ownsAmp
);
  shadow_t  cfg;
  strobes_t strb;

  amp_key_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgAutoMode(cfgAutoMode),
    .cfgExtGate(cfgExtGate), .cfgReload(cfgReload), .ampReg(ampReg),
    .updateStrobe(updateStrobe), .keyPin(keyPin), .cfg(cfg), .strb(strb)
  );

  amp_key_dp u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .otherAmp(otherAmp),
    .ampOut(ampOut), .ownsAmp(ownsAmp)
  );

  assert_owner_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    (updateStrobe && cfgEnable) |=> ownsAmp);
  assert_yield_when_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (updateStrobe && !cfgEnable) |=> (!ownsAmp && ampOut == otherAmp));
endmodule

// File: tb/amp_keyer_test.sv
module amp_keyer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0, cfgAutoMode = 1'b0, cfgExtGate = 1'b0, cfgReload = 1'b0;
  logic [31:0] ampReg = '0;
  logic        updateStrobe = 1'b0;
  logic        keyPin = 1'b0;
  logic [13:0] otherAmp = '0;
  logic [13:0] ampOut;
  logic        ownsAmp;
  int          nChecks = 0;
  int          nFails = 0;

  amp_keyer uut (.*);

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; updateStrobe = 1'b0; keyPin = 1'b0;
    cfgEnable = 1'b0; cfgAutoMode = 1'b0; cfgExtGate = 1'b0; cfgReload = 1'b0;
    tick(); tick();
    rstN = 1'b1;
  endtask

  task automatic loadCfg(input logic en, input logic au, input logic ext, input logic rl,
                         input int rate, input int scale, input int code);
    cfgEnable = en; cfgAutoMode = au; cfgExtGate = ext; cfgReload = rl;
    ampReg = {rate[15:0], scale[13:0], code[1:0]};
    updateStrobe = 1'b1;
    tick();
    updateStrobe = 1'b0;
  endtask

  task automatic rampCase(input int rate, input int code, input int scale);
    int s, r, nMax, exp;
    s = 1 << code;
    r = (rate == 0) ? 1 : rate;
    nMax = r * ((scale + s - 1) / s) + 2;
    doReset();
    keyPin = 1'b1;
    loadCfg(1, 1, 0, 1, rate, scale, code);
    for (int n = 1; n <= nMax; n++) begin
      tick();
      exp = (n / r) * s;
      if (exp > scale) exp = scale;
      check("R7 R9 R10 rise", ampOut, exp);
    end
    keyPin = 1'b0;
    loadCfg(1, 1, 0, 1, rate, scale, code);
    check("R11 no step on reload edge", ampOut, scale);
    for (int n = 1; n <= nMax; n++) begin
      tick();
      exp = scale - (n / r) * s;
      if (exp < 0) exp = 0;
      check("R8 R9 R10 fall", ampOut, exp);
    end
  endtask

  initial begin
    int scales[5] = '{0, 1, 5, 16'h1555, 16'h3FFF};
    int held;

    // R1 reset state
    otherAmp = 14'd1234;
    doReset();
    check("R1 ownsAmp", ownsAmp, 0);
    check("R1 ampOut", ampOut, 1234);

    // R3 disabled: pin, mode and gate ignored, other source passes
    for (int v = 0; v < 16; v++) begin
      otherAmp = 14'(v * 977);
      keyPin = v[0];
      loadCfg(0, v[1], v[2], 0, 3, 100, 1);
      check("R3 owner", ownsAmp, 0);
      check("R3 passthrough", ampOut, (v * 977) & 16'h3FFF);
    end

    // R4 R5 R6 manual sweep
    for (int i = 0; i < 5; i++) begin
      for (int ext = 0; ext < 2; ext++) begin
        for (int pin = 0; pin < 2; pin++) begin
          doReset();
          otherAmp = 14'h2AAA;
          keyPin = pin[0];
          loadCfg(1, 0, ext[0], 0, 0, scales[i], 0);
          check("R4 owner", ownsAmp, 1);
          tick();
          check((ext == 1) ? "R6 manual gated" : "R5 manual", ampOut,
                (ext == 1 && pin == 0) ? 0 : scales[i]);
          keyPin = ~keyPin;
          tick();
          check((ext == 1) ? "R6 pin toggle" : "R5 pin ignored", ampOut,
                (ext == 1 && pin == 1) ? 0 : scales[i]);
        end
      end
    end

    // R2 fields change without strobe: no effect
    doReset();
    loadCfg(1, 0, 0, 0, 0, 300, 0);
    tick();
    check("R2 latched", ampOut, 300);
    ampReg = {16'd0, 14'd999, 2'd0};
    cfgEnable = 1'b0;
    tick(); tick();
    check("R2 no strobe scale", ampOut, 300);
    check("R2 no strobe enable", ownsAmp, 1);

    // R7..R11 automatic ramps
    for (int rt = 0; rt < 5; rt++)
      for (int c = 0; c < 4; c++)
        rampCase((rt == 4) ? 5 : rt, c, 37);
    rampCase(1, 3, 16'h3FFF);
    rampCase(2, 2, 16'h3FFE);

    // R12 freeze and resume
    doReset();
    keyPin = 1'b1;
    loadCfg(1, 1, 0, 1, 1, 100, 0);
    for (int n = 0; n < 10; n++) tick();
    check("R12 ramp before freeze", ampOut, 10);
    otherAmp = 14'd77;
    loadCfg(0, 1, 0, 0, 1, 100, 0);
    held = 11;
    for (int n = 0; n < 20; n++) begin
      keyPin = n[0];
      tick();
      check("R12 frozen output is other", ampOut, 77);
    end
    keyPin = 1'b1;
    loadCfg(1, 1, 0, 1, 1, 100, 0);
    check("R12 resume held", ampOut, held);
    tick();
    check("R12 resume step", ampOut, held + 1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule